// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block performs the multi-cycle stack transfers of a small 8-bit processor that has a 16-bit stack pointer and a byte-wide memory bus. The surrounding core decodes the instruction. It then presents a command code, the operands, and a one-cycle `start`. The sequencer drives the memory address, the write data and the read/write strobes one machine cycle per clock. It also keeps the stack pointer.

When a command finishes, the block updates three things: the popped word, the new program counter for calls and returns, and the number of machine cycles the command took. A push moves downward through memory and stores the high byte first. A pop moves upward and fetches the low byte first. Conditional calls and returns use the `cond_ok` input, which is sampled with `start`.

Memory is combinational on read: `mem_rdata` must reflect `mem_addr` within the same clock. A write strobe is committed by the memory at the rising edge that ends the cycle.

Top module: `stk_seq`

## Requirements
- R1: Command 0 (pair push) takes 4 cycles. It writes `pair_in[15:8]` at SP-1, then `pair_in[7:0]` at SP-2, and leaves SP at SP-2.
- R2: Command 1 (pair pop) takes 3 cycles. It reads the low byte at SP, then the high byte at SP+1, presents them as `pop_data`, and leaves SP at SP+2.
- R3: Command 2 (accumulator/flag push) behaves like R1 with one difference in the low byte. The high byte is `pair_in[15:8]`. The low byte is built from `flags_in`: bit 3 (zero) goes to bit 7, bit 2 (subtract) to bit 6, bit 1 (half carry) to bit 5, bit 0 (carry) to bit 4, and bits 3..0 of the byte are zero.
- R4: Command 3 (accumulator/flag pop) behaves like R2, except that bits 3..0 of `pop_data` are forced to zero.
- R5: Command 4 (call) takes 6 cycles. It pushes `ret_addr` as in R1, then pulses `pc_load` with `pc_out` = `target`. Command 5 (conditional call) does the same when `cond_ok` is high. When `cond_ok` is low it takes 3 cycles, with no memory access, no SP change and no `pc_load`.
- R6: Command 6 (return) takes 4 cycles. It pops as in R2 and pulses `pc_load` with `pc_out` set to the popped word. Command 7 (conditional return) takes 5 cycles when `cond_ok` is high. When `cond_ok` is low it takes 2 cycles, with no read, no SP change and no `pc_load`.
- R7: Command 8 (store SP) takes 5 cycles. It writes SP[7:0] at `target` and SP[15:8] at `target`+1, and leaves SP unchanged.
- R8: SP arithmetic wraps modulo 2^16 in both directions.
- R9: `busy` is high for exactly N clocks starting at the edge that accepts `start`, where N is the command's cycle count. `done` is high for one clock right after. From that point, `mcycles` reads N.
- R10: A `start` raised while `busy` is high is ignored.
- R11: Synchronous reset sets SP to 0xFFFE and clears `busy`, `done`, `mcycles`, `pc_out` and `pc_load`.
- R12: While idle, `sp_wr` loads SP from `sp_wval`. While busy, `sp_wr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (accepted when idle) |
| cmd | input | 4 | Command code |
| cond_ok | input | 1 | Condition result for conditional call/return |
| pair_in | input | 16 | Register pair to push (high byte = accumulator for command 2) |
| flags_in | input | 4 | Zero, subtract, half-carry, carry (bits 3..0) |
| ret_addr | input | 16 | Address of the following instruction, pushed by calls |
| target | input | 16 | Call target, or destination address for store SP |
| sp_wr | input | 1 | Load SP while idle |
| sp_wval | input | 16 | Value for the SP load |
| mem_rdata | input | 8 | Read data from memory |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| mcycles | output | 3 | Machine cycles of the last completed command |
| sp | output | 16 | Stack pointer |
| pop_data | output | 16 | Word assembled by the last pop |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Pulse, with `done`, when a call or return was taken |

## Verification
The hardest situations to reach are the address wrap across 0x0000/0xFFFF and the ignored start during a busy period. For the wrap, the bench loads SP to 0x0001 while idle, pushes across the boundary and pops back. For the ignored start, the bench raises a second `start` with a different command in the first busy cycle and confirms that the cycle count and memory traffic match the first command alone. Both directions of each conditional command are run so the short, access-free paths are covered.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 4;
    localparam int CNT_W  = 3;

    typedef enum logic [3:0] {
        CMD_PUSH    = 4'd0,
        CMD_POP     = 4'd1,
        CMD_PUSH_AF = 4'd2,
        CMD_POP_AF  = 4'd3,
        CMD_CALL    = 4'd4,
        CMD_CALL_IF = 4'd5,
        CMD_RET     = 4'd6,
        CMD_RET_IF  = 4'd7,
        CMD_SAVE_SP = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        ACT_IDLE, ACT_DEC, ACT_WR_HI, ACT_WR_LO,
        ACT_RD_LO, ACT_RD_HI, ACT_ABS_LO, ACT_ABS_HI
    } act_e;

    function automatic logic is_call(cmd_e c);
        return (c == CMD_CALL) || (c == CMD_CALL_IF);
    endfunction

    function automatic logic is_ret(cmd_e c);
        return (c == CMD_RET) || (c == CMD_RET_IF);
    endfunction

    function automatic logic [CNT_W-1:0] op_len(cmd_e c, logic taken);
        case (c)
            CMD_PUSH, CMD_PUSH_AF: return 3'd4;
            CMD_POP, CMD_POP_AF:   return 3'd3;
            CMD_CALL:              return 3'd6;
            CMD_CALL_IF:           return taken ? 3'd6 : 3'd3;
            CMD_RET:               return 3'd4;
            CMD_RET_IF:            return taken ? 3'd5 : 3'd2;
            CMD_SAVE_SP:           return 3'd5;
            default:               return 3'd1;
        endcase
    endfunction

    // Per-cycle action of a command, given its step index
    function automatic act_e op_act(cmd_e c, logic taken, logic [CNT_W-1:0] idx);
        logic [CNT_W-1:0] off;
        logic [CNT_W-1:0] k;
        act_e a;
        a = ACT_IDLE;
        case (c)
            CMD_PUSH, CMD_PUSH_AF, CMD_CALL, CMD_CALL_IF: begin
                off = is_call(c) ? 3'd2 : 3'd0;
                k   = idx - off;
                if (taken && idx >= off) begin
                    case (k)
                        3'd0:    a = ACT_DEC;
                        3'd1:    a = ACT_WR_HI;
                        3'd2:    a = ACT_WR_LO;
                        default: a = ACT_IDLE;
                    endcase
                end
            end
            CMD_POP, CMD_POP_AF, CMD_RET, CMD_RET_IF: begin
                off = (c == CMD_RET_IF) ? 3'd1 : 3'd0;
                k   = idx - off;
                if (taken && idx >= off) begin
                    case (k)
                        3'd0:    a = ACT_RD_LO;
                        3'd1:    a = ACT_RD_HI;
                        default: a = ACT_IDLE;
                    endcase
                end
            end
            CMD_SAVE_SP: begin
                if (idx == 3'd2)      a = ACT_ABS_LO;
                else if (idx == 3'd3) a = ACT_ABS_HI;
            end
            default: a = ACT_IDLE;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       cmd,
    input  logic             cond_ok,
    output logic             busy,
    output logic             done,
    output logic             accept,
    output logic             last,
    output cmd_e             cmd_q,
    output logic             taken_q,
    output act_e             act,
    output logic [CNT_W-1:0] mcycles
);
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] len_q;
    cmd_e             cmd_in;
    logic             taken_in;

    assign cmd_in   = cmd_e'(cmd);
    assign taken_in = (cmd_in == CMD_CALL_IF || cmd_in == CMD_RET_IF) ? cond_ok : 1'b1;
    assign accept   = start && !busy;
    assign last     = busy && (step == len_q - 1'b1);
    assign act      = busy ? op_act(cmd_q, taken_q, step) : ACT_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            step    <= '0;
            len_q   <= '0;
            cmd_q   <= CMD_PUSH;
            taken_q <= 1'b0;
            mcycles <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                step    <= '0;
                cmd_q   <= cmd_in;
                taken_q <= taken_in;
                len_q   <= op_len(cmd_in, taken_in);
            end else if (busy) begin
                if (last) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    mcycles <= len_q;
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && $stable(cmd_q) && $stable(taken_q)));
endmodule

// File: rtl/stk_dp.sv
module stk_dp
    import stk_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_INIT = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              busy,
    input  logic              last,
    input  act_e              act,
    input  cmd_e              cmd_q,
    input  logic              taken_q,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] pair_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] target,
    input  logic              sp_wr,
    input  logic [ADDR_W-1:0] sp_wval,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] pop_data,
    output logic [ADDR_W-1:0] pc_out,
    output logic              pc_load
);
    localparam int HALF = ADDR_W / 2;

    logic [ADDR_W-1:0] wword;
    logic [ADDR_W-1:0] tgt;
    logic [HALF-1:0]   lo_q, hi_q;
    cmd_e              cmd_in;

    assign cmd_in   = cmd_e'(cmd);
    assign pop_data = {hi_q, lo_q};

    always_comb begin
        mem_addr  = sp;
        mem_wdata = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        case (act)
            ACT_WR_HI:  begin mem_wr = 1'b1; mem_wdata = wword[ADDR_W-1:HALF]; end
            ACT_WR_LO:  begin mem_wr = 1'b1; mem_wdata = wword[HALF-1:0]; end
            ACT_RD_LO,
            ACT_RD_HI:  mem_rd = 1'b1;
            ACT_ABS_LO: begin mem_wr = 1'b1; mem_addr = tgt; mem_wdata = sp[HALF-1:0]; end
            ACT_ABS_HI: begin mem_wr = 1'b1; mem_addr = tgt + 1'b1; mem_wdata = sp[ADDR_W-1:HALF]; end
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp      <= SP_INIT;
            wword   <= '0;
            tgt     <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            pc_out  <= '0;
            pc_load <= 1'b0;
        end else begin
            pc_load <= 1'b0;
            if (accept) begin
                tgt <= target;
                if (cmd_in == CMD_PUSH_AF)
                    wword <= {pair_in[ADDR_W-1:HALF], flags_in, {(HALF-FLAG_W){1'b0}}};
                else if (is_call(cmd_in))
                    wword <= ret_addr;
                else
                    wword <= pair_in;
            end else if (!busy && sp_wr) begin
                sp <= sp_wval;
            end
            case (act)
                ACT_DEC, ACT_WR_HI: sp <= sp - 1'b1;
                ACT_RD_LO: begin
                    lo_q <= (cmd_q == CMD_POP_AF)
                            ? {mem_rdata[HALF-1:FLAG_W], {FLAG_W{1'b0}}} : mem_rdata;
                    sp   <= sp + 1'b1;
                end
                ACT_RD_HI: begin
                    hi_q <= mem_rdata;
                    sp   <= sp + 1'b1;
                end
                default: ;
            endcase
            if (last && taken_q) begin
                if (is_call(cmd_q)) begin
                    pc_out  <= tgt;
                    pc_load <= 1'b1;
                end else if (is_ret(cmd_q)) begin
                    pc_out  <= {hi_q, lo_q};
                    pc_load <= 1'b1;
                end
            end
        end
    end

    p_pop_up_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (sp == $past(sp) + 16'd1));
    p_push_down_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && act == ACT_WR_HI) |=> (sp == $past(sp) - 16'd1));
    p_af_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_RD_LO && cmd_q == CMD_POP_AF) |=> (pop_data[3:0] == 4'h0));
    p_idle_sp_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !sp_wr) |=> $stable(sp));
    p_store_sp_r7: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_ABS_LO) |=> $stable(sp));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter logic [15:0] SP_INIT = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  cmd,
    input  logic        cond_ok,
    input  logic [15:0] pair_in,
    input  logic [3:0]  flags_in,
    input  logic [15:0] ret_addr,
    input  logic [15:0] target,
    input  logic        sp_wr,
    input  logic [15:0] sp_wval,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        busy,
    output logic        done,
    output logic [2:0]  mcycles,
    output logic [15:0] sp,
    output logic [15:0] pop_data,
    output logic [15:0] pc_out,
    output logic        pc_load
);
    logic accept, last, taken_q;
    cmd_e cmd_q;
    act_e act;

    stk_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .cond_ok(cond_ok),
        .busy(busy), .done(done), .accept(accept), .last(last),
        .cmd_q(cmd_q), .taken_q(taken_q), .act(act), .mcycles(mcycles)
    );

    stk_dp #(.SP_INIT(SP_INIT)) u_dp (
        .clk(clk), .rst(rst), .accept(accept), .busy(busy), .last(last),
        .act(act), .cmd_q(cmd_q), .taken_q(taken_q), .cmd(cmd),
        .pair_in(pair_in), .flags_in(flags_in), .ret_addr(ret_addr),
        .target(target), .sp_wr(sp_wr), .sp_wval(sp_wval),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .sp(sp), .pop_data(pop_data),
        .pc_out(pc_out), .pc_load(pc_load)
    );
endmodule

// File: tb/sim_stk_seq.sv
module sim_stk_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  cmd = '0;
    logic        cond_ok = 1'b0;
    logic [15:0] pair_in = '0, ret_addr = '0, target = '0, sp_wval = '0;
    logic [3:0]  flags_in = '0;
    logic        sp_wr = 1'b0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, sp, pop_data, pc_out;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, busy, done, pc_load;
    logic [2:0]  mcycles;

    logic [7:0]  mem [256];
    logic [23:0] exp_wr [$];
    logic [15:0] exp_rd [$];
    int          checks = 0;
    int          errs   = 0;
    logic        got_pcl;
    string       cur_tag = "R0";

    always #10 clk = ~clk;

    stk_seq u0 (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .cond_ok(cond_ok),
        .pair_in(pair_in), .flags_in(flags_in), .ret_addr(ret_addr),
        .target(target), .sp_wr(sp_wr), .sp_wval(sp_wval),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
        .mcycles(mcycles), .sp(sp), .pop_data(pop_data), .pc_out(pc_out),
        .pc_load(pc_load)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Monitor: compare memory traffic against the scoreboard queues
    always @(negedge clk) begin
        if (!rst && mem_wr) begin
            if (exp_wr.size() == 0) chk(cur_tag, {mem_addr, mem_wdata}, 24'h0, "unexpected write");
            else chk(cur_tag, {mem_addr, mem_wdata}, exp_wr.pop_front(), "write addr/data");
        end
        if (!rst && mem_rd) begin
            if (exp_rd.size() == 0) chk(cur_tag, mem_addr, 16'h0, "unexpected read");
            else chk(cur_tag, mem_addr, exp_rd.pop_front(), "read addr");
        end
    end

    task automatic run(string tag, logic [3:0] c, logic cnd, int exp_n, bit poke);
        int n;
        cur_tag = tag;
        @(negedge clk);
        cmd = c; cond_ok = cnd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy) begin
            if (poke && n == 0) begin start = 1'b1; cmd = 4'd1; sp_wr = 1'b1; sp_wval = 16'h5555; end
            else begin start = 1'b0; sp_wr = 1'b0; end
            n++;
            @(negedge clk);
        end
        start = 1'b0; sp_wr = 1'b0;
        chk(tag, n, exp_n, "busy cycles (R9)");
        chk(tag, done, 1, "done pulse (R9)");
        chk(tag, mcycles, exp_n[2:0], "mcycles (R9)");
        got_pcl = pc_load;
        @(negedge clk);
        chk(tag, done, 0, "done falls (R9)");
        chk(tag, busy, 0, "idle after");
        chk(tag, exp_wr.size() + exp_rd.size(), 0, "missing accesses");
    endtask

    task automatic set_sp(logic [15:0] v);
        @(negedge clk);
        sp_wr = 1'b1; sp_wval = v;
        @(negedge clk);
        sp_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11", sp, 16'hFFFE, "sp");
        chk("R11", {busy, done, pc_load}, 0, "busy/done/pc_load");
        chk("R11", mcycles, 0, "mcycles");
        chk("R11", pc_out, 0, "pc_out");

        // R12 SP load while idle
        set_sp(16'h1080);
        chk("R12", sp, 16'h1080, "sp load");

        // R1 push pair, with a start and sp_wr raised while busy (R10, R12)
        pair_in = 16'hBEEF;
        exp_wr.push_back({16'h107F, 8'hBE});
        exp_wr.push_back({16'h107E, 8'hEF});
        run("R1_R10", 4'd0, 1'b0, 4, 1'b1);
        chk("R1", sp, 16'h107E, "sp after push");
        chk("R12", sp, 16'h107E, "sp_wr ignored while busy");

        // R2 pop pair
        exp_rd.push_back(16'h107E);
        exp_rd.push_back(16'h107F);
        run("R2", 4'd1, 1'b0, 3, 1'b0);
        chk("R2", pop_data, 16'hBEEF, "pop_data");
        chk("R2", sp, 16'h1080, "sp after pop");

        // R3 push accumulator/flags: Z=1 N=0 H=1 C=0 -> 0xA0
        pair_in = 16'h5A77; flags_in = 4'b1010;
        exp_wr.push_back({16'h107F, 8'h5A});
        exp_wr.push_back({16'h107E, 8'hA0});
        run("R3", 4'd2, 1'b0, 4, 1'b0);
        chk("R3", mem[8'h7E], 8'hA0, "flag byte");

        // R4 pop accumulator/flags with a dirty low nibble
        @(negedge clk); mem[8'h7E] = 8'h3F;
        exp_rd.push_back(16'h107E);
        exp_rd.push_back(16'h107F);
        run("R4", 4'd3, 1'b0, 3, 1'b0);
        chk("R4", pop_data, 16'h5A30, "masked pop_data");

        // R5 call
        ret_addr = 16'h1234; target = 16'h4000;
        exp_wr.push_back({16'h107F, 8'h12});
        exp_wr.push_back({16'h107E, 8'h34});
        run("R5", 4'd4, 1'b0, 6, 1'b0);
        chk("R5", {got_pcl, pc_out}, {1'b1, 16'h4000}, "pc_load/pc_out");
        chk("R5", sp, 16'h107E, "sp after call");

        // R5 conditional call not taken
        target = 16'h7777;
        run("R5_nt", 4'd5, 1'b0, 3, 1'b0);
        chk("R5", {got_pcl, pc_out}, {1'b0, 16'h4000}, "no pc_load");
        chk("R5", sp, 16'h107E, "sp unchanged");

        // R6 conditional return not taken
        run("R6_nt", 4'd7, 1'b0, 2, 1'b0);
        chk("R6", {got_pcl, sp}, {1'b0, 16'h107E}, "no pc_load, sp");

        // R6 conditional return taken
        exp_rd.push_back(16'h107E);
        exp_rd.push_back(16'h107F);
        run("R6_t", 4'd7, 1'b1, 5, 1'b0);
        chk("R6", {got_pcl, pc_out}, {1'b1, 16'h1234}, "pc from stack");
        chk("R6", sp, 16'h1080, "sp after ret");

        // R5 conditional call taken, then R6 plain return
        ret_addr = 16'hABCD; target = 16'h2222;
        exp_wr.push_back({16'h107F, 8'hAB});
        exp_wr.push_back({16'h107E, 8'hCD});
        run("R5_t", 4'd5, 1'b1, 6, 1'b0);
        chk("R5", {got_pcl, pc_out}, {1'b1, 16'h2222}, "taken cond call");
        exp_rd.push_back(16'h107E);
        exp_rd.push_back(16'h107F);
        run("R6", 4'd6, 1'b0, 4, 1'b0);
        chk("R6", {got_pcl, pc_out}, {1'b1, 16'hABCD}, "ret pc");

        // R7 store SP to absolute address
        target = 16'h20F0;
        exp_wr.push_back({16'h20F0, 8'h80});
        exp_wr.push_back({16'h20F1, 8'h10});
        run("R7", 4'd8, 1'b0, 5, 1'b0);
        chk("R7", sp, 16'h1080, "sp unchanged");

        // R8 wrap across 0x0000 / 0xFFFF
        set_sp(16'h0001);
        pair_in = 16'hCAFE;
        exp_wr.push_back({16'h0000, 8'hCA});
        exp_wr.push_back({16'hFFFF, 8'hFE});
        run("R8_push", 4'd0, 1'b0, 4, 1'b0);
        chk("R8", sp, 16'hFFFF, "sp wrapped down");
        exp_rd.push_back(16'hFFFF);
        exp_rd.push_back(16'h0000);
        run("R8_pop", 4'd1, 1'b0, 3, 1'b0);
        chk("R8", {sp, pop_data}, {16'h0001, 16'hCAFE}, "sp wrapped up / data");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule